// File: doc/BRIEF.md
# Pause Frame Transmit Inserter

This block sits on the byte path ahead of an Ethernet transmitter. It merges ordinary data frames from an upstream source with flow-control pause frames that software asks for through a register write. The write carries a request flag and a 16-bit pause time. The block builds the pause frame itself and sends it only between data frames. A data frame that is already running always finishes before the pause frame goes out.

The block also keeps a two-bit completion status register with a matching mask. Software clears a status bit by writing a 1 to it. A single interrupt line is raised while any unmasked status bit is set. The downstream stage receives bytes over a valid/ready handshake that carries start and end markers. It also receives a strobe that asks it to append the frame check sequence to the generated pause frame, and a transmit-enable level that frames each transfer.

Top module: `pause_tx_inserter`

## Requirements
- R1: A write with `ctl_wr_en` high and `ctl_wr_data[16]` set records a pause request, and `ctl_wr_data[15:0]` becomes its pause time. A write with bit 16 clear has no effect and sends no frame.
- R2: A pause frame starts only while `cfg_tx_en`, `cfg_full_duplex` and `cfg_flow_en` are all high. A request made while any of them is low stays pending and is sent once all three are high.
- R3: When no data frame is in progress, a pending request starts a pause frame without waiting for any data traffic.
- R4: A request that arrives during a data frame is held until that frame's end beat has been accepted. The data frame bytes reach the output unchanged, and the pause frame follows it.
- R5: A pause frame is exactly FRAME_LEN bytes (60 by default) and is marked start on byte 0 and end on the last byte. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `station_addr` with its top byte first. Bytes 12-13 are 88 08. Bytes 14-15 are 00 01. Bytes 16-17 are the pause time with the high byte first. All remaining bytes are 00.
- R6: `tx_crc_add` is high only on the accepted end beat of a pause frame, and never during a data frame.
- R7: A second request made while an earlier one is still pending replaces its pause time. Only one pause frame is sent, and it carries the newer value.
- R8: `irq_status[0]` is set when a data frame's end beat is accepted. `irq_status[1]` is set when a pause frame's end beat is accepted. Both bits latch whatever the mask holds, and a set bit stays set until it is cleared.
- R9: `irq` is high exactly when some bit is set in both `irq_status` and `irq_mask`. `irq_mask` is loaded by `mask_wr_en`.
- R10: A write with `irq_wr_en` clears each status bit whose position in `irq_wr_data` is 1. Status bits at positions written 0 are unchanged.
- R11: `tx_en` is high for every beat of a frame and low for at least one cycle after each accepted end beat. This includes the cycle between a data frame and the pause frame that follows it.
- R12: While `tx_valid` is high and `tx_ready` is low, the offered byte and its markers are held. A pause frame is not corrupted by any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmitter enabled |
| cfg_full_duplex | input | 1 | Link runs full duplex |
| cfg_flow_en | input | 1 | Transmit flow control enabled |
| station_addr | input | 48 | Own MAC address, used as the pause frame source |
| ctl_wr_en | input | 1 | Pause control register write strobe |
| ctl_wr_data | input | 17 | Bit 16: request flag; bits 15:0: pause time |
| irq_wr_en | input | 1 | Status clear write strobe |
| irq_wr_data | input | 2 | Write-one-to-clear pattern (bit 0 data done, bit 1 pause done) |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 2 | New mask value |
| irq_status | output | 2 | Latched completion status |
| irq_mask | output | 2 | Current mask |
| irq | output | 1 | Interrupt request |
| dat_valid | input | 1 | Upstream data byte valid |
| dat_data | input | 8 | Upstream data byte |
| dat_sof | input | 1 | Upstream first byte of frame |
| dat_eof | input | 1 | Upstream last byte of frame |
| dat_ready | output | 1 | Upstream byte accepted |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | Output first byte of frame |
| tx_eof | output | 1 | Output last byte of frame |
| tx_crc_add | output | 1 | Append frame check sequence to this pause frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_en | output | 1 | High while a frame is being transferred |

## Verification
The hold-under-back-pressure property assumes that the upstream source keeps `dat_valid`, its byte and its markers steady until `dat_ready` accepts them. It also assumes every data frame opens with a start marker. The bench source model follows both rules: it advances only on an accepted handshake and presents each frame from byte 0. It randomizes `tx_ready` to exercise stalls in both data and pause frames. Register writes are one-cycle pulses, and the bench never issues a new request in the same cycle that a pause frame is launched.

// File: rtl/pause_ins_pkg.sv
package pause_ins_pkg;
  localparam int BYTE_W    = 8;
  localparam int PTIME_W   = 16;
  localparam int REQ_BIT   = PTIME_W;
  localparam int CTLW_W    = PTIME_W + 1;
  localparam int STAT_W    = 2;
  localparam int STAT_DATA = 0;
  localparam int STAT_CTRL = 1;
  localparam int HDR_LEN   = 18;

  localparam logic [47:0] PAUSE_DEST  = 48'h0180_C200_0001;
  localparam logic [15:0] MAC_CTRL_TY = 16'h8808;
  localparam logic [15:0] PAUSE_OPC   = 16'h0001;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_DATA = 2'd1,
    ARB_CTRL = 2'd2,
    ARB_GAP  = 2'd3
  } arb_state_e;
endpackage

// File: rtl/pause_req_latch.sv
module pause_req_latch
  import pause_ins_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTLW_W-1:0]  wr_data,
  input  logic               take,
  output logic               pending,
  output logic [PTIME_W-1:0] active_time
);
  logic               pend_q, pend_d;
  logic [PTIME_W-1:0] ptime_q, ptime_d;
  logic [PTIME_W-1:0] act_q, act_d;

  // Launch clears the request; a new write in the same cycle re-arms it.
  always_comb begin
    pend_d  = pend_q;
    ptime_d = ptime_q;
    act_d   = act_q;
    if (take) begin
      pend_d = 1'b0;
      act_d  = ptime_q;
    end
    if (wr_en && wr_data[REQ_BIT]) begin
      pend_d  = 1'b1;
      ptime_d = wr_data[PTIME_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ptime_q <= '0;
      act_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      ptime_q <= ptime_d;
      act_q   <= act_d;
    end
  end

  assign pending     = pend_q;
  assign active_time = act_q;
endmodule

// File: rtl/ctrl_frame_gen.sv
module ctrl_frame_gen
  import pause_ins_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               advance,
  input  logic [47:0]        station_addr,
  input  logic [PTIME_W-1:0] ptime,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               first_o,
  output logic               last_o
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)        cnt_d = '0;
    else if (advance) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Header fields are selected by position; everything past them is padding.
  always_comb begin
    int pos;
    pos = int'(cnt_q);
    if (pos < 6)
      byte_o = BYTE_W'(PAUSE_DEST >> (8 * (5 - pos)));
    else if (pos < 12)
      byte_o = BYTE_W'(station_addr >> (8 * (11 - pos)));
    else if (pos < 14)
      byte_o = BYTE_W'(MAC_CTRL_TY >> (8 * (13 - pos)));
    else if (pos < 16)
      byte_o = BYTE_W'(PAUSE_OPC >> (8 * (15 - pos)));
    else if (pos < HDR_LEN)
      byte_o = BYTE_W'(ptime >> (8 * (17 - pos)));
    else
      byte_o = '0;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(FRAME_LEN - 1));
endmodule

// File: rtl/tx_arbiter.sv
module tx_arbiter
  import pause_ins_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_allowed,
  input  logic ctrl_allowed,
  input  logic ctrl_pending,
  input  logic dat_valid,
  input  logic dat_sof,
  input  logic dat_eof,
  input  logic tx_ready,
  input  logic gen_last,
  output logic ctrl_start,
  output logic data_done,
  output logic ctrl_done,
  output logic in_data,
  output logic in_ctrl
);
  arb_state_e st_q, st_d;

  assign in_data   = (st_q == ARB_DATA);
  assign in_ctrl   = (st_q == ARB_CTRL);
  assign data_done = in_data && dat_valid && tx_ready && dat_eof;
  assign ctrl_done = in_ctrl && tx_ready && gen_last;

  // Pause frames win only at a frame boundary (IDLE); GAP forces a quiet cycle.
  always_comb begin
    st_d       = st_q;
    ctrl_start = 1'b0;
    unique case (st_q)
      ARB_IDLE: begin
        if (ctrl_pending && ctrl_allowed) begin
          st_d       = ARB_CTRL;
          ctrl_start = 1'b1;
        end else if (data_allowed && dat_valid && dat_sof) begin
          st_d = ARB_DATA;
        end
      end
      ARB_DATA: if (data_done) st_d = ARB_GAP;
      ARB_CTRL: if (ctrl_done) st_d = ARB_GAP;
      ARB_GAP:  st_d = ARB_IDLE;
      default:  st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import pause_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_bits,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic              mask_en,
  input  logic [STAT_W-1:0] mask_bits,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q, stat_d, mask_q, mask_d;

  // A completion event in the same cycle as its clear keeps the bit set.
  always_comb begin
    stat_d = stat_q;
    if (clr_en) stat_d = stat_d & ~clr_bits;
    stat_d = stat_d | set_bits;
    mask_d = mask_en ? mask_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/pause_tx_inserter.sv
module pause_tx_inserter
  import pause_ins_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_en,
  input  logic              cfg_full_duplex,
  input  logic              cfg_flow_en,
  input  logic [47:0]       station_addr,
  input  logic              ctl_wr_en,
  input  logic [CTLW_W-1:0] ctl_wr_data,
  input  logic              irq_wr_en,
  input  logic [STAT_W-1:0] irq_wr_data,
  input  logic              mask_wr_en,
  input  logic [STAT_W-1:0] mask_wr_data,
  output logic [STAT_W-1:0] irq_status,
  output logic [STAT_W-1:0] irq_mask,
  output logic              irq,
  input  logic              dat_valid,
  input  logic [BYTE_W-1:0] dat_data,
  input  logic              dat_sof,
  input  logic              dat_eof,
  output logic              dat_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_crc_add,
  input  logic              tx_ready,
  output logic              tx_en
);
  logic               pend, ctrl_start, data_done, ctrl_done;
  logic               in_data, ctrl_active, gen_first, gen_last;
  logic [PTIME_W-1:0] act_time;
  logic [BYTE_W-1:0]  gen_byte;
  logic               ctrl_allowed;
  logic [STAT_W-1:0]  set_bits;

  assign ctrl_allowed = cfg_tx_en && cfg_full_duplex && cfg_flow_en;

  pause_req_latch u_req (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .take(ctrl_start),
    .pending(pend), .active_time(act_time)
  );

  ctrl_frame_gen #(.FRAME_LEN(FRAME_LEN)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .start(ctrl_start), .advance(ctrl_active && tx_ready),
    .station_addr(station_addr), .ptime(act_time),
    .byte_o(gen_byte), .first_o(gen_first), .last_o(gen_last)
  );

  tx_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .data_allowed(cfg_tx_en), .ctrl_allowed(ctrl_allowed),
    .ctrl_pending(pend),
    .dat_valid(dat_valid), .dat_sof(dat_sof), .dat_eof(dat_eof),
    .tx_ready(tx_ready), .gen_last(gen_last),
    .ctrl_start(ctrl_start), .data_done(data_done), .ctrl_done(ctrl_done),
    .in_data(in_data), .in_ctrl(ctrl_active)
  );

  always_comb begin
    set_bits            = '0;
    set_bits[STAT_DATA] = data_done;
    set_bits[STAT_CTRL] = ctrl_done;
  end

  irq_regs u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_bits(set_bits),
    .clr_en(irq_wr_en), .clr_bits(irq_wr_data),
    .mask_en(mask_wr_en), .mask_bits(mask_wr_data),
    .status(irq_status), .mask(irq_mask), .irq(irq)
  );

  // Output mux: data frames pass straight through, pause frames come from the generator.
  assign tx_valid   = in_data ? dat_valid : ctrl_active;
  assign tx_data    = in_data ? dat_data  : gen_byte;
  assign tx_sof     = in_data ? dat_sof   : (ctrl_active && gen_first);
  assign tx_eof     = in_data ? dat_eof   : (ctrl_active && gen_last);
  assign tx_crc_add = ctrl_active && gen_last;
  assign dat_ready  = in_data && tx_ready;
  assign tx_en      = in_data || ctrl_active;
endmodule

// File: rtl/pause_tx_inserter_chk.sv
module pause_tx_inserter_chk
  import pause_ins_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_tx_en,
  input logic              cfg_full_duplex,
  input logic              cfg_flow_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_sof,
  input logic              tx_eof,
  input logic              tx_crc_add,
  input logic              tx_en,
  input logic              irq,
  input logic [STAT_W-1:0] irq_status,
  input logic [STAT_W-1:0] irq_mask,
  input logic              irq_wr_en,
  input logic [STAT_W-1:0] irq_wr_data,
  input logic              ctrl_on
);
  // R11
  eof_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eof) |=> !tx_en);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  // R6
  crc_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_crc_add |-> (tx_valid && tx_eof && ctrl_on));

  // R2
  ctrl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_on) |-> $past(cfg_tx_en && cfg_full_duplex && cfg_flow_en));

  // R4
  no_cut_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_on) |-> !$past(tx_en));

  // R8
  data_stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[STAT_DATA] && !(irq_wr_en && irq_wr_data[STAT_DATA])) |=> irq_status[STAT_DATA]);

  // R8
  ctrl_stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[STAT_CTRL] && !(irq_wr_en && irq_wr_data[STAT_CTRL])) |=> irq_status[STAT_CTRL]);

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irq_mask != '0) && (irq_status != '0)));
endmodule

bind pause_tx_inserter pause_tx_inserter_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_tx_en(cfg_tx_en), .cfg_full_duplex(cfg_full_duplex), .cfg_flow_en(cfg_flow_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_crc_add(tx_crc_add), .tx_en(tx_en),
  .irq(irq), .irq_status(irq_status), .irq_mask(irq_mask),
  .irq_wr_en(irq_wr_en), .irq_wr_data(irq_wr_data),
  .ctrl_on(ctrl_active)
);

// File: tb/tb_pause_tx_inserter.sv
`timescale 1ns/1ps
module tb_pause_tx_inserter;
  logic        clk;
  logic        rst_n;
  logic        cfg_tx_en, cfg_full_duplex, cfg_flow_en;
  logic [47:0] station_addr;
  logic        ctl_wr_en;
  logic [16:0] ctl_wr_data;
  logic        irq_wr_en;
  logic [1:0]  irq_wr_data;
  logic        mask_wr_en;
  logic [1:0]  mask_wr_data;
  logic [1:0]  irq_status, irq_mask;
  logic        irq;
  logic        dat_valid, dat_sof, dat_eof, dat_ready;
  logic [7:0]  dat_data;
  logic        tx_valid, tx_sof, tx_eof, tx_crc_add, tx_ready, tx_en;
  logic [7:0]  tx_data;

  pause_tx_inserter dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] src_q[$];
  logic [7:0] ref_q[$];
  int  src_idx = 0;
  bit  src_on  = 0;
  int  ready_pct = 100;

  logic [7:0] fm [0:15][0:127];
  int  flen [0:15];
  bit  fcrc [0:15];
  int  fcnt = 0;
  int  cur_len = 0;
  bit  gap_pend = 0;
  int  gap_bad = 0;
  int  en_cycles = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl_byte(int i, logic [47:0] sa, logic [15:0] q);
    case (i)
      0: return 8'h01;   1: return 8'h80;   2: return 8'hC2;
      3: return 8'h00;   4: return 8'h00;   5: return 8'h01;
      6: return sa[47:40]; 7: return sa[39:32]; 8: return sa[31:24];
      9: return sa[23:16]; 10: return sa[15:8]; 11: return sa[7:0];
      12: return 8'h88;  13: return 8'h08;
      14: return 8'h00;  15: return 8'h01;
      16: return q[15:8]; 17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    ctl_wr_en  = 1'b0;
    irq_wr_en  = 1'b0;
    mask_wr_en = 1'b0;
    tx_ready   = ($urandom_range(99) < ready_pct);
    if (src_on) begin
      dat_valid = 1'b1;
      dat_data  = src_q[src_idx];
      dat_sof   = (src_idx == 0);
      dat_eof   = (src_idx == src_q.size() - 1);
    end else begin
      dat_valid = 1'b0; dat_data = 8'h00; dat_sof = 1'b0; dat_eof = 1'b0;
    end
    #1;
    if (tx_en) en_cycles++;
    if (gap_pend) begin
      if (tx_en) gap_bad++;
      gap_pend = 0;
    end
    if (tx_valid && tx_ready) begin
      if (tx_sof) cur_len = 0;
      if (cur_len < 128) fm[fcnt % 16][cur_len] = tx_data;
      cur_len++;
      if (tx_eof) begin
        flen[fcnt % 16] = cur_len;
        fcrc[fcnt % 16] = tx_crc_add;
        fcnt++;
        gap_pend = 1;
      end
    end
    if (dat_valid && dat_ready) begin
      src_idx++;
      if (src_idx >= src_q.size()) src_on = 0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_frames();
    fcnt = 0; en_cycles = 0; gap_bad = 0;
  endtask

  task automatic wait_frames(input int n, input string rq);
    int g = 0;
    while (fcnt < n && g < 3000) begin tick(); g++; end
    chk(fcnt >= n, rq, "frame count reached", fcnt, n);
    tick();
  endtask

  task automatic req(input logic [15:0] q, input bit flag);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = {flag, q};
  endtask

  task automatic clr_stat(input logic [1:0] v);
    irq_wr_en = 1'b1; irq_wr_data = v; tick();
  endtask

  task automatic set_mask(input logic [1:0] v);
    mask_wr_en = 1'b1; mask_wr_data = v; tick();
  endtask

  task automatic start_data(input int len);
    src_q.delete(); ref_q.delete();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      src_q.push_back(b); ref_q.push_back(b);
    end
    src_idx = 0; src_on = 1;
  endtask

  task automatic check_ctrl(input int k, input logic [15:0] q, input string rq);
    int bad = -1;
    chk(flen[k] == 60, "R5", "pause frame length", flen[k], 60);
    for (int j = 0; j < 60 && j < flen[k]; j++)
      if (bad < 0 && fm[k][j] !== exp_ctrl_byte(j, station_addr, q)) bad = j;
    chk(bad < 0, rq, "pause frame byte mismatch",
        (bad < 0) ? 0 : fm[k][bad], (bad < 0) ? 0 : exp_ctrl_byte(bad, station_addr, q));
    chk(fcrc[k] == 1'b1, "R6", "crc strobe on pause end", fcrc[k], 1);
  endtask

  task automatic check_data(input int k, input string rq);
    int bad = -1;
    chk(flen[k] == ref_q.size(), rq, "data frame length", flen[k], ref_q.size());
    for (int j = 0; j < ref_q.size() && j < flen[k]; j++)
      if (bad < 0 && fm[k][j] !== ref_q[j]) bad = j;
    chk(bad < 0, rq, "data frame byte mismatch", bad, -1);
    chk(fcrc[k] == 1'b0, "R6", "no crc strobe on data frame", fcrc[k], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_tx_en = 0; cfg_full_duplex = 0; cfg_flow_en = 0;
    station_addr = 48'h02AB_CD12_3456;
    ctl_wr_en = 0; ctl_wr_data = '0;
    irq_wr_en = 0; irq_wr_data = '0;
    mask_wr_en = 0; mask_wr_data = '0;
    dat_valid = 0; dat_data = 0; dat_sof = 0; dat_eof = 0; tx_ready = 0;
    ticks(4);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk(tx_valid == 0 && tx_en == 0, "R11", "idle after reset", {tx_valid, tx_en}, 0);
    chk(irq_status == 0 && irq == 0, "R8", "status clear after reset", {irq_status, irq}, 0);

    cfg_tx_en = 1; cfg_full_duplex = 1; cfg_flow_en = 1;

    // R3 R5 R8 R9: request while idle, mask off
    clear_frames();
    req(16'h1234, 1'b1);
    wait_frames(1, "R3");
    check_ctrl(0, 16'h1234, "R5");
    chk(irq_status == 2'b10, "R8", "pause done status only", irq_status, 2'b10);
    chk(irq == 0, "R9", "masked status gives no irq", irq, 0);

    // R10 clear
    clr_stat(2'b10); tick();
    chk(irq_status == 2'b00, "R10", "status after clear", irq_status, 0);

    // R9 R12: unmasked, with back-pressure
    set_mask(2'b10);
    clear_frames();
    ready_pct = 55;
    req(16'hBEEF, 1'b1);
    wait_frames(1, "R12");
    check_ctrl(0, 16'hBEEF, "R12");
    chk(irq == 1, "R9", "unmasked pause done raises irq", irq, 1);
    clr_stat(2'b10); tick();
    chk(irq == 0, "R9", "irq drops after clear", irq, 0);
    ready_pct = 100;

    // R4 R8 R11: request during a data frame
    set_mask(2'b11);
    clear_frames();
    start_data(40);
    while (src_idx < 10) tick();
    req(16'h5678, 1'b1);
    wait_frames(1, "R4");
    check_data(0, "R4");
    chk(irq_status == 2'b01, "R8", "data done before pause done", irq_status, 2'b01);
    wait_frames(2, "R4");
    check_ctrl(1, 16'h5678, "R4");
    chk(irq_status == 2'b11, "R8", "both done bits", irq_status, 2'b11);
    chk(gap_bad == 0, "R11", "tx_en gap after each frame", gap_bad, 0);

    // R10 partial clears
    clr_stat(2'b01); tick();
    chk(irq_status == 2'b10, "R10", "clear bit0 keeps bit1", irq_status, 2'b10);
    clr_stat(2'b00); tick();
    chk(irq_status == 2'b10, "R10", "zero write keeps status", irq_status, 2'b10);
    clr_stat(2'b10); tick();

    // R2 gating
    clear_frames();
    cfg_flow_en = 0;
    req(16'h0F0F, 1'b1);
    ticks(100);
    chk(fcnt == 0 && en_cycles == 0, "R2", "no frame while flow control off", fcnt, 0);
    cfg_flow_en = 1; cfg_full_duplex = 0;
    ticks(50);
    chk(fcnt == 0 && en_cycles == 0, "R2", "no frame in half duplex", fcnt, 0);
    cfg_full_duplex = 1;
    wait_frames(1, "R2");
    check_ctrl(0, 16'h0F0F, "R2");
    clr_stat(2'b11);

    // R1 write without request flag
    clear_frames();
    req(16'h4444, 1'b0);
    ticks(100);
    chk(fcnt == 0, "R1", "write without flag sends nothing", fcnt, 0);

    // R7 overwrite while pending
    clear_frames();
    start_data(50);
    while (src_idx < 5) tick();
    req(16'h1111, 1'b1); tick(); tick();
    req(16'h2222, 1'b1);
    wait_frames(2, "R7");
    ticks(150);
    chk(fcnt == 2, "R7", "single pause frame after overwrite", fcnt, 2);
    check_ctrl(1, 16'h2222, "R7");
    clr_stat(2'b11);

    // R8 data frame alone
    clear_frames();
    start_data(30);
    wait_frames(1, "R8");
    check_data(0, "R8");
    chk(irq_status == 2'b01, "R8", "data done only", irq_status, 2'b01);
    clr_stat(2'b11);

    // Random mix
    for (int it = 0; it < 12; it++) begin
      logic [15:0] q;
      bit with_data;
      int len, at;
      q = 16'($urandom);
      with_data = $urandom_range(1);
      ready_pct = 40 + $urandom_range(60);
      clear_frames();
      if (with_data) begin
        len = 20 + $urandom_range(50);
        at  = 1 + $urandom_range(len - 3);
        start_data(len);
        while (src_idx < at) tick();
        req(q, 1'b1);
        wait_frames(2, "R4");
        check_data(0, "R4");
        check_ctrl(1, q, "R5");
        chk(irq_status == 2'b11, "R8", "random both done", irq_status, 2'b11);
      end else begin
        req(q, 1'b1);
        wait_frames(1, "R3");
        check_ctrl(0, q, "R5");
        chk(irq_status == 2'b10, "R8", "random pause done", irq_status, 2'b10);
      end
      chk(gap_bad == 0, "R11", "random gap", gap_bad, 0);
      clr_stat(2'b11); tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule